// File: doc/BRIEF.md
# LAN Interrupt Status and Acknowledge Controller

This block gathers the interrupt causes of a LAN controller into one status byte and drives a level-sensitive, active-low interrupt pin toward the host. Single-cycle event pulses come from several sources:
- the command unit, when a command completes and when the unit's state changes;
- the receive unit, for a finished frame, an early receive and not-ready;
- the management interface, when a transfer completes;
- a software request;
- receipt of a flow-control pause frame.

Each pulse sets a sticky pending bit. The pending bit stays set until the host clears it by writing a one to the matching position of the acknowledge byte.

A second byte, the interrupt control byte, holds the interrupt masks and a software trigger. It has one global mask bit, six per-source mask bits and a write-only software-interrupt bit. The masks act only on the pin. Pending status is always recorded and stays readable. A configuration input selects when the command-unit event fires: either when the unit leaves its active state, or only when it arrives at idle. The host bus decoding is outside the block; it receives byte-write strobes with their data.

Top module: `lan_irq_status`

## Requirements
- R1: Synchronous active-high reset clears all pending bits, masks and the global mask, so `irq_n` is 1. An event pulse sets its status bit one clock edge later. The `status_byte` encoding is: [7] command complete, [6] frame received or early receive, [5] CU-state event, [4] RU not ready, [3] management done, [2] software interrupt, [1] reserved, [0] pause frame.
- R2: An acknowledge write clears every pending bit whose `ack_data` bit is 1. Zero bits, and ones written to non-pending bits, change nothing. A one at bit 6 clears both the frame-received and the early-receive causes.
- R3: `irq_n` is 0 while at least one unmasked pending cause remains. A partial acknowledge leaves it low. It returns to 1 one edge after the last unmasked cause is cleared.
- R4: Per-source masks take effect after an interrupt-control write and act on the pin only. The positions in `ictl_data` are: [7] command complete, [6] frame received, [5] CU-state, [4] RU not ready, [3] early receive, [2] pause. Management-done and software causes have no per-source mask.
- R5: The global mask (`ictl_data[0]`) forces `irq_n` to 1 whatever is pending and whatever the per-source masks hold.
- R6: Writing 1 to `ictl_data[1]` with `ictl_data[0]`=0 sets status bit 2. The same bit with `ictl_data[0]`=1 does nothing. `ictl_rd` returns {masks, 0, global mask}, so the trigger bit always reads 0.
- R7: With `cfg_ci_mode`=0, the CU-state event fires when `cu_state` moves from an active code (`1x`) to idle (`00`) or suspended (`01`).
- R8: With `cfg_ci_mode`=1, the CU-state event fires only when `cu_state` moves into idle from any other code. Active to suspended does not fire it.
- R9: A management-done pulse is recorded only while `mdi_irq_en` is 1.
- R10: When an event and an acknowledge of the same bit fall in one cycle, the bit stays set.
- R11: Early receive is reported in status bit 6 and gated by its own mask. The frame-received mask does not silence it.
- R12: Status bit 1 is always 0, even with every cause pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ci_mode | input | 1 | 0: CU event on leaving active; 1: only on entering idle |
| mdi_irq_en | input | 1 | Enables recording of management-done events |
| cu_state | input | 2 | Command unit state: 00 idle, 01 suspended, 1x active |
| ev_cmd_done | input | 1 | Command-complete pulse |
| ev_frame_rx | input | 1 | Frame-received pulse |
| ev_early_rx | input | 1 | Early-receive pulse |
| ev_ru_not_ready | input | 1 | Receive unit left ready pulse |
| ev_mdi_done | input | 1 | Management transfer complete pulse |
| ev_pause_rx | input | 1 | Pause frame received pulse |
| ack_we | input | 1 | Acknowledge byte write strobe |
| ack_data | input | 8 | Acknowledge byte, write-1-to-clear |
| ictl_we | input | 1 | Interrupt control byte write strobe |
| ictl_data | input | 8 | Masks [7:2], software trigger [1], global mask [0] |
| status_byte | output | 8 | Pending cause byte |
| ictl_rd | output | 8 | Interrupt control readback |
| irq_n | output | 1 | Level interrupt, active low |

## Verification
Every result here lands exactly one clock edge after the cycle that carries the stimulus. This holds for status bits set by pulses or by the software trigger, for clears from an acknowledge, for mask changes, and for the CU-state event, which compares the registered previous state with the state sampled at that edge. The bench drives inputs 1 ns after a rising edge, advances its reference model at the next rising edge, and compares all three outputs 1 ns later. No result is ever expected in the same cycle as its stimulus or two edges away.

// File: rtl/lan_irq_pkg.sv
package lan_irq_pkg;

    localparam int STAT_W = 8;
    localparam int MASK_W = 6;
    localparam int CU_W   = 2;
    localparam int PEND_W = STAT_W + 1;

    // pending vector positions (0..7 mirror the status byte)
    localparam int B_PAUSE = 0;
    localparam int B_RSVD  = 1;
    localparam int B_SWI   = 2;
    localparam int B_MDI   = 3;
    localparam int B_RNR   = 4;
    localparam int B_CUEV  = 5;
    localparam int B_FRX   = 6;
    localparam int B_CMD   = 7;
    localparam int B_ERX   = STAT_W;

    // mask register positions
    localparam int M_PAUSE = 0;
    localparam int M_ERX   = 1;
    localparam int M_RNR   = 2;
    localparam int M_CUEV  = 3;
    localparam int M_FRX   = 4;
    localparam int M_CMD   = 5;

    typedef enum logic [CU_W-1:0] {
        CU_IDLE   = 2'b00,
        CU_SUSP   = 2'b01,
        CU_ACT_LO = 2'b10,
        CU_ACT_HI = 2'b11
    } cu_state_e;

    typedef struct packed {
        logic cmd;
        logic frx;
        logic erx;
        logic cuev;
        logic rnr;
        logic mdi;
        logic swi;
        logic pause;
    } ev_s;

    function automatic logic cu_active(input logic [CU_W-1:0] s);
        return s[CU_W-1];
    endfunction

    function automatic logic cu_event(input logic ci_mode,
                                      input logic [CU_W-1:0] prev,
                                      input logic [CU_W-1:0] cur);
        if (ci_mode)
            return (prev != CU_IDLE) && (cur == CU_IDLE);
        return cu_active(prev) && !cu_active(cur);
    endfunction

    function automatic logic [PEND_W-1:0] ev_to_vec(input ev_s e);
        logic [PEND_W-1:0] v;
        v          = '0;
        v[B_PAUSE] = e.pause;
        v[B_SWI]   = e.swi;
        v[B_MDI]   = e.mdi;
        v[B_RNR]   = e.rnr;
        v[B_CUEV]  = e.cuev;
        v[B_FRX]   = e.frx;
        v[B_CMD]   = e.cmd;
        v[B_ERX]   = e.erx;
        return v;
    endfunction

    function automatic logic [PEND_W-1:0] ack_to_vec(input logic [STAT_W-1:0] a);
        logic [PEND_W-1:0] v;
        v          = {1'b0, a};
        v[B_ERX]   = a[B_FRX];
        return v;
    endfunction

    // per pending bit: 1 = blocked from the pin
    function automatic logic [PEND_W-1:0] mask_to_vec(input logic [MASK_W-1:0] m);
        logic [PEND_W-1:0] v;
        v          = '0;
        v[B_PAUSE] = m[M_PAUSE];
        v[B_RSVD]  = 1'b1;
        v[B_RNR]   = m[M_RNR];
        v[B_CUEV]  = m[M_CUEV];
        v[B_FRX]   = m[M_FRX];
        v[B_CMD]   = m[M_CMD];
        v[B_ERX]   = m[M_ERX];
        return v;
    endfunction

    function automatic logic [STAT_W-1:0] pend_to_status(input logic [PEND_W-1:0] p);
        logic [STAT_W-1:0] s;
        s         = p[STAT_W-1:0];
        s[B_FRX]  = p[B_FRX] | p[B_ERX];
        s[B_RSVD] = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/lan_irq_evt.sv
module lan_irq_evt
    import lan_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_ci_mode,
    input  logic            mdi_irq_en,
    input  logic [CU_W-1:0] cu_state,
    input  logic            ev_cmd_done,
    input  logic            ev_frame_rx,
    input  logic            ev_early_rx,
    input  logic            ev_ru_not_ready,
    input  logic            ev_mdi_done,
    input  logic            ev_pause_rx,
    input  logic            swi_req,
    output logic [PEND_W-1:0] set_vec
);
    logic [CU_W-1:0] cu_prev_q;
    ev_s             ev;

    always_ff @(posedge clk) begin
        if (rst) cu_prev_q <= CU_IDLE;
        else     cu_prev_q <= cu_state;
    end

    always_comb begin
        ev.cmd   = ev_cmd_done;
        ev.frx   = ev_frame_rx;
        ev.erx   = ev_early_rx;
        ev.cuev  = cu_event(cfg_ci_mode, cu_prev_q, cu_state);
        ev.rnr   = ev_ru_not_ready;
        ev.mdi   = ev_mdi_done & mdi_irq_en;
        ev.swi   = swi_req;
        ev.pause = ev_pause_rx;
        set_vec  = ev_to_vec(ev);
    end
endmodule

// File: rtl/lan_irq_pend.sv
module lan_irq_pend
    import lan_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PEND_W-1:0] set_vec,
    input  logic              ack_we,
    input  logic [STAT_W-1:0] ack_data,
    output logic [PEND_W-1:0] pend
);
    logic [PEND_W-1:0] clr_vec;

    assign clr_vec = ack_we ? ack_to_vec(ack_data) : '0;

    for (genvar i = 0; i < PEND_W; i++) begin : g_bit
        if (i == B_RSVD) begin : g_rsvd
            assign pend[i] = 1'b0;
        end else begin : g_live
            logic q;
            always_ff @(posedge clk) begin
                if (rst)             q <= 1'b0;
                else if (set_vec[i]) q <= 1'b1;   // event beats acknowledge
                else if (clr_vec[i]) q <= 1'b0;
            end
            assign pend[i] = q;
        end
    end
endmodule

// File: rtl/lan_irq_ctl.sv
module lan_irq_ctl
    import lan_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ictl_we,
    input  logic [STAT_W-1:0] ictl_data,
    input  logic [PEND_W-1:0] pend,
    output logic              swi_req,
    output logic [STAT_W-1:0] ictl_rd,
    output logic              irq_n
);
    localparam int GM_BIT = 0;
    localparam int SI_BIT = 1;
    localparam int MSK_LO = 2;

    logic [MASK_W-1:0] mask_q;
    logic              gmask_q;
    logic [PEND_W-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            gmask_q <= 1'b0;
        end else if (ictl_we) begin
            mask_q  <= ictl_data[MSK_LO +: MASK_W];
            gmask_q <= ictl_data[GM_BIT];
        end
    end

    // global mask in the same write outranks the trigger
    assign swi_req = ictl_we & ictl_data[SI_BIT] & ~ictl_data[GM_BIT];
    assign ictl_rd = {mask_q, 1'b0, gmask_q};
    assign live    = pend & ~mask_to_vec(mask_q);
    assign irq_n   = gmask_q | ~(|live);
endmodule

// File: rtl/lan_irq_status.sv
module lan_irq_status
    import lan_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_ci_mode,
    input  logic        mdi_irq_en,
    input  logic [1:0]  cu_state,
    input  logic        ev_cmd_done,
    input  logic        ev_frame_rx,
    input  logic        ev_early_rx,
    input  logic        ev_ru_not_ready,
    input  logic        ev_mdi_done,
    input  logic        ev_pause_rx,
    input  logic        ack_we,
    input  logic [7:0]  ack_data,
    input  logic        ictl_we,
    input  logic [7:0]  ictl_data,
    output logic [7:0]  status_byte,
    output logic [7:0]  ictl_rd,
    output logic        irq_n
);
    logic [PEND_W-1:0] set_vec;
    logic [PEND_W-1:0] pend;
    logic              swi_req;

    lan_irq_evt u_evt (
        .clk(clk), .rst(rst), .cfg_ci_mode(cfg_ci_mode), .mdi_irq_en(mdi_irq_en),
        .cu_state(cu_state), .ev_cmd_done(ev_cmd_done), .ev_frame_rx(ev_frame_rx),
        .ev_early_rx(ev_early_rx), .ev_ru_not_ready(ev_ru_not_ready),
        .ev_mdi_done(ev_mdi_done), .ev_pause_rx(ev_pause_rx), .swi_req(swi_req),
        .set_vec(set_vec)
    );

    lan_irq_pend u_pend (
        .clk(clk), .rst(rst), .set_vec(set_vec), .ack_we(ack_we),
        .ack_data(ack_data), .pend(pend)
    );

    lan_irq_ctl u_ctl (
        .clk(clk), .rst(rst), .ictl_we(ictl_we), .ictl_data(ictl_data),
        .pend(pend), .swi_req(swi_req), .ictl_rd(ictl_rd), .irq_n(irq_n)
    );

    assign status_byte = pend_to_status(pend);
endmodule

// File: rtl/lan_irq_status_chk.sv
module lan_irq_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_ci_mode,
    input logic       mdi_irq_en,
    input logic [1:0] cu_state,
    input logic       ev_cmd_done,
    input logic       ev_frame_rx,
    input logic       ev_early_rx,
    input logic       ev_ru_not_ready,
    input logic       ev_mdi_done,
    input logic       ev_pause_rx,
    input logic       ack_we,
    input logic [7:0] ack_data,
    input logic       ictl_we,
    input logic [7:0] ictl_data,
    input logic [7:0] status_byte,
    input logic [7:0] ictl_rd,
    input logic       irq_n
);
    logic quiet;
    assign quiet = !ev_cmd_done && !ev_frame_rx && !ev_early_rx && !ev_ru_not_ready
                && !ev_mdi_done && !ev_pause_rx && !ictl_we;

    // R1: without an acknowledge nothing pending is lost
    p_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        !ack_we |=> ((status_byte & $past(status_byte)) == $past(status_byte)));

    // R2: acknowledged bits are clear next cycle (CU-state bit excluded)
    p_ack_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (ack_we && quiet) |=> ((status_byte & $past(ack_data) & 8'hDF) == 8'h00));

    // R3: pin low only with something pending
    p_pin_level_r3: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (status_byte != 8'h00));

    // R5: global mask keeps the pin high
    p_gmask_r5: assert property (@(posedge clk) disable iff (rst)
        ictl_rd[0] |-> irq_n);

    // R8: in idle-only mode the CU bit rises only after a move to idle
    p_ci_mode_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(status_byte[5]) && $past(cfg_ci_mode)) |-> ($past(cu_state) == 2'b00));

    // R9: management-done bit rises only from an enabled pulse
    p_mdi_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(status_byte[3]) |-> $past(ev_mdi_done && mdi_irq_en));

    // R10: an event wins over a same-cycle acknowledge
    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        ev_cmd_done |=> status_byte[7]);
endmodule

bind lan_irq_status lan_irq_status_chk u_chk (.*);

// File: tb/tb_lan_irq_status.sv
`timescale 1ns/1ps
module tb_lan_irq_status;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_ci_mode = 1'b0, mdi_irq_en = 1'b0;
    logic [1:0] cu_state = 2'b00;
    logic       ev_cmd_done = 0, ev_frame_rx = 0, ev_early_rx = 0;
    logic       ev_ru_not_ready = 0, ev_mdi_done = 0, ev_pause_rx = 0;
    logic       ack_we = 0, ictl_we = 0;
    logic [7:0] ack_data = '0, ictl_data = '0;
    logic [7:0] status_byte, ictl_rd;
    logic       irq_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    logic [8:0] m_pend = '0;   // [7:0] status positions, [8] early receive
    logic [5:0] m_mask = '0;
    logic       m_gm   = 1'b0;
    logic [1:0] m_cuprev = 2'b00;

    always #2.5 clk = ~clk;

    lan_irq_status dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s    = m_pend[7:0];
        s[6] = m_pend[6] | m_pend[8];
        s[1] = 1'b0;
        return s;
    endfunction

    function automatic logic exp_irq();
        logic [8:0] blk;
        blk = {m_mask[1], m_mask[5], m_mask[4], m_mask[3], m_mask[2], 1'b0, 1'b0, 1'b1, m_mask[0]};
        if (m_gm) return 1'b1;
        return ~|(m_pend & ~blk);
    endfunction

    task automatic model_step();
        logic [8:0] n;
        logic       cuev;
        n = m_pend;
        if (ack_we) begin
            for (int i = 0; i < 8; i++) if (ack_data[i]) n[i] = 1'b0;
            if (ack_data[6]) n[8] = 1'b0;
        end
        cuev = cfg_ci_mode ? (m_cuprev != 2'b00 && cu_state == 2'b00)
                           : (m_cuprev[1] && !cu_state[1]);
        if (ev_cmd_done)                  n[7] = 1'b1;
        if (ev_frame_rx)                  n[6] = 1'b1;
        if (ev_early_rx)                  n[8] = 1'b1;
        if (cuev)                         n[5] = 1'b1;
        if (ev_ru_not_ready)              n[4] = 1'b1;
        if (ev_mdi_done && mdi_irq_en)    n[3] = 1'b1;
        if (ictl_we && ictl_data[1] && !ictl_data[0]) n[2] = 1'b1;
        if (ev_pause_rx)                  n[0] = 1'b1;
        if (ictl_we) begin
            m_mask = ictl_data[7:2];
            m_gm   = ictl_data[0];
        end
        m_cuprev = cu_state;
        m_pend   = n;
    endtask

    // one cycle: model advances at the edge, outputs compared 1 ns later
    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        chk("R1/R2 status model", status_byte, exp_status());
        chk("R3/R4/R5 irq_n model", irq_n, exp_irq());
        chk("R6 ictl_rd model", ictl_rd, {m_mask, 1'b0, m_gm});
    endtask

    task automatic ack(input logic [7:0] d);
        ack_we = 1; ack_data = d; tick(); ack_we = 0; ack_data = '0;
    endtask

    task automatic ictl(input logic [7:0] d);
        ictl_we = 1; ictl_data = d; tick(); ictl_we = 0; ictl_data = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk("R1 reset status", status_byte, 8'h00);
        chk("R1 reset irq_n", irq_n, 1'b1);
        chk("R1 reset ictl_rd", ictl_rd, 8'h00);

        ev_cmd_done = 1; tick(); ev_cmd_done = 0;
        chk("R1 cmd sets bit7", status_byte, 8'h80);
        chk("R3 pin asserted", irq_n, 1'b0);

        ack(8'h00); chk("R2 zero ack ignored", status_byte, 8'h80);
        ack(8'h7F); chk("R2 non-pending ack ignored", status_byte, 8'h80);
        ack(8'h80); chk("R2 ack clears", status_byte, 8'h00);
        chk("R3 pin released", irq_n, 1'b1);

        ev_cmd_done = 1; ev_ru_not_ready = 1; tick(); ev_cmd_done = 0; ev_ru_not_ready = 0;
        chk("R1 two causes", status_byte, 8'h90);
        ack(8'h80);
        chk("R3 partial ack status", status_byte, 8'h10);
        chk("R3 partial ack pin low", irq_n, 1'b0);
        ack(8'h10); chk("R3 full ack pin high", irq_n, 1'b1);

        ictl(8'h80);
        ev_cmd_done = 1; tick(); ev_cmd_done = 0;
        chk("R4 masked still recorded", status_byte, 8'h80);
        chk("R4 masked pin high", irq_n, 1'b1);
        ictl(8'h00); chk("R4 unmask pin low", irq_n, 1'b0);
        ack(8'h80);

        ictl(8'h03);
        chk("R6 trigger with global mask dropped", status_byte, 8'h00);
        chk("R6 readback trigger zero", ictl_rd, 8'h01);
        ictl(8'h02);
        chk("R6 trigger sets bit2", status_byte, 8'h04);
        chk("R6 trigger pin low", irq_n, 1'b0);
        chk("R6 readback zero", ictl_rd, 8'h00);
        ictl(8'h01); chk("R5 global mask pin high", irq_n, 1'b1);
        ictl(8'hFD); chk("R5 global mask with all masks", irq_n, 1'b1);
        ictl(8'h00); ack(8'h04);

        cfg_ci_mode = 0;
        cu_state = 2'b10; tick(); chk("R7 idle to active no event", status_byte, 8'h00);
        cu_state = 2'b01; tick(); chk("R7 active to suspended fires", status_byte, 8'h20);
        ack(8'h20);
        cu_state = 2'b11; tick();
        cfg_ci_mode = 1;
        cu_state = 2'b01; tick(); chk("R8 active to suspended silent", status_byte, 8'h00);
        cu_state = 2'b00; tick(); chk("R8 entering idle fires", status_byte, 8'h20);
        ack(8'h20); cfg_ci_mode = 0;

        mdi_irq_en = 0; ev_mdi_done = 1; tick(); ev_mdi_done = 0;
        chk("R9 disabled mdi ignored", status_byte, 8'h00);
        mdi_irq_en = 1; ev_mdi_done = 1; tick(); ev_mdi_done = 0;
        chk("R9 enabled mdi recorded", status_byte, 8'h08);
        ack(8'h08);

        ev_cmd_done = 1; tick();
        ack_we = 1; ack_data = 8'h80; tick(); ack_we = 0; ev_cmd_done = 0;
        chk("R10 event beats ack", status_byte, 8'h80);
        ack(8'h80);

        ictl(8'h40);
        ev_early_rx = 1; tick(); ev_early_rx = 0;
        chk("R11 early rx in bit6", status_byte, 8'h40);
        chk("R11 fr mask does not silence early rx", irq_n, 1'b0);
        ack(8'h40); chk("R11 ack clears early rx", status_byte, 8'h00);
        ictl(8'h08);
        ev_early_rx = 1; tick(); ev_early_rx = 0;
        chk("R11 early rx own mask", irq_n, 1'b1);
        ack(8'h40); ictl(8'h00);

        cu_state = 2'b10; tick();
        ev_cmd_done = 1; ev_frame_rx = 1; ev_ru_not_ready = 1; ev_mdi_done = 1; ev_pause_rx = 1;
        cu_state = 2'b00; ictl_we = 1; ictl_data = 8'h02; tick();
        ev_cmd_done = 0; ev_frame_rx = 0; ev_ru_not_ready = 0; ev_mdi_done = 0; ev_pause_rx = 0;
        ictl_we = 0; ictl_data = '0;
        chk("R12 all causes, reserved clear", status_byte, 8'hFD);
        ack(8'hFF); chk("R2 ack all", status_byte, 8'h00);

        for (int c = 0; c < 3000; c++) begin
            if (c % 500 == 0) begin
                cfg_ci_mode = $urandom_range(0, 1);
                mdi_irq_en  = $urandom_range(0, 1);
            end
            ev_cmd_done     = ($urandom_range(0, 7) == 0);
            ev_frame_rx     = ($urandom_range(0, 7) == 0);
            ev_early_rx     = ($urandom_range(0, 9) == 0);
            ev_ru_not_ready = ($urandom_range(0, 9) == 0);
            ev_mdi_done     = ($urandom_range(0, 7) == 0);
            ev_pause_rx     = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 5) == 0) cu_state = 2'($urandom_range(0, 3));
            ack_we   = ($urandom_range(0, 3) == 0);
            ack_data = 8'($urandom);
            ictl_we  = ($urandom_range(0, 15) == 0);
            ictl_data = 8'($urandom);
            if ($urandom_range(0, 3) != 0) ictl_data[0] = 1'b0;
            tick();
        end
        ev_cmd_done = 0; ev_frame_rx = 0; ev_early_rx = 0; ev_ru_not_ready = 0;
        ev_mdi_done = 0; ev_pause_rx = 0; ack_we = 0; ictl_we = 0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule